// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and the status registers of a 32-bit RISC core that runs in six operating modes: user, fast interrupt, normal interrupt, supervisor, abort and undefined. The core presents a 4-bit architectural register index on each of two read ports and one write port. The block translates that index into a physical storage slot according to the mode held in the low five bits of the current status word. Registers 0 to 7 and the program counter (index 15) are common to every mode. The fast-interrupt mode swaps in its own copies of indices 8 to 14. The other four privileged modes swap only indices 13 and 14, which serve as stack pointer and link register.

The block also keeps the current status word and five saved status words, one per privileged mode. An exception strobe with a target-mode code does three things on a single clock edge: it copies the current status into the target mode's saved word, moves the current mode field to the target, and writes the supplied return link into the target mode's register 14. A restore strobe copies the active mode's saved word back into the current status for exception return. Reads are purely combinational and nothing is forwarded from the write port.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 name one physical set. A value written to one of them in any mode reads back under the same index in every other mode.
- R2: In fast-interrupt mode (mode field 10001), indices 8 to 14 reach seven private registers. Writes there are never visible in any other mode, and writes from other modes are never visible there.
- R3: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each own private copies of indices 13 and 14. They share indices 8 to 12 with user mode (10000).
- R4: Index 15 is a single program-counter register that every mode reads and writes alike.
- R5: Read data is combinational from the storage the current mode selects. A write lands on the clock edge, so a read of the register being written in the same cycle returns the old value.
- R6: When exc_take is high and exc_mode names a privileged mode, one edge does all of the following: the target's saved status takes the old current status; the current status mode field (bits 4:0) becomes exc_mode with all other bits kept; the target's index-14 register takes exc_link.
- R7: An exc_take whose exc_mode is user or an unrecognised code changes no register and no status word.
- R8: While the active mode is user or unrecognised, saved_rd_data reads zero and saved_wr_en has no effect. In a privileged mode, saved_wr_en overwrites that mode's saved status.
- R9: psr_restore copies the active mode's saved status into the current status. It is ignored in user or unrecognised mode.
- R10: After reset the current status is 0x000000D3: supervisor mode, with the interrupt mask (bit 7) and the fast-interrupt mask (bit 6) set. All general registers and saved status words are zero.
- R11: A mode field that matches none of the six codes maps registers exactly as user mode does.
- R12: Priorities apply within one cycle. An exception outranks psr_restore, and psr_restore outranks psr_wr_en. The exception's link write outranks a general write to the same physical register. An exception's capture outranks saved_wr_en on the same saved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Register index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode code being entered on exception |
| exc_link | input | 32 | Return link written to the target's index 14 |
| psr_wr_en | input | 1 | Current status write enable |
| psr_wr_data | input | 32 | Current status write data |
| psr_restore | input | 1 | Copy active saved status into current status |
| saved_wr_en | input | 1 | Active mode's saved status write enable |
| saved_wr_data | input | 32 | Saved status write data |
| saved_rd_data | output | 32 | Active mode's saved status, zero in user mode |
| psr_q | output | 32 | Current status word |

## Verification
Several properties are checked on every cycle. The index map keeps fast-interrupt accesses to indices 8 to 14 inside the private range, and it routes indices 0 to 12 of the other modes onto the user set. Exception entry always lands the mode field and the saved-status capture on the next edge. Rejected exceptions and user-mode restores leave the status stable. The saved-status port reads zero in user mode, and the link write wins a collision. Only the bench's scenarios can show that banked data really stays separate across mode switches, that same-cycle reads return old values, and that reset clears every slot. The bench mixes seeded random traffic with directed cases for these and compares every read against an independent per-mode model.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   localparam int MODE_W = 5;

   localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

   typedef enum logic [2:0] {
      BANK_USR = 3'd0,
      BANK_FIQ = 3'd1,
      BANK_IRQ = 3'd2,
      BANK_SVC = 3'd3,
      BANK_ABT = 3'd4,
      BANK_UND = 3'd5
   } bank_e;

   localparam int NUM_BANKS  = 6;
   localparam int NUM_PRIV   = NUM_BANKS - 1;
   localparam int NUM_LOW    = 8;
   localparam int HI_FIRST   = NUM_LOW;
   localparam int STACK_IDX  = 13;
   localparam int LINK_IDX   = 14;
   localparam int PC_IDX     = 15;
   localparam int NUM_HI     = PC_IDX - HI_FIRST;
   localparam int NUM_SMALL  = NUM_PRIV - 1;
   localparam int USR_BASE   = NUM_LOW;
   localparam int FIQ_BASE   = USR_BASE + NUM_HI;
   localparam int PRIV_BASE  = FIQ_BASE + NUM_HI;
   localparam int PC_SLOT    = PRIV_BASE + 2 * NUM_SMALL;
   localparam int NUM_PHYS   = PC_SLOT + 1;

   function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
      case (m)
         MODE_FIQ: return BANK_FIQ;
         MODE_IRQ: return BANK_IRQ;
         MODE_SVC: return BANK_SVC;
         MODE_ABT: return BANK_ABT;
         MODE_UND: return BANK_UND;
         default:  return BANK_USR;
      endcase
   endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
   import bankreg_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PHYS_W = 5
) (
   input  bank_e             bank,
   input  logic [IDX_W-1:0]  idx,
   output logic [PHYS_W-1:0] phys
);

   if (IDX_W != 4) begin : g_bad_idx
      $error("bankreg_map: IDX_W must be 4");
   end
   if ((1 << PHYS_W) < NUM_PHYS) begin : g_bad_phys
      $error("bankreg_map: PHYS_W too narrow");
   end

   int slot;

   always_comb begin
      slot = 0;
      if (int'(idx) == PC_IDX) begin
         slot = PC_SLOT;
      end else if (int'(idx) < NUM_LOW) begin
         slot = int'(idx);
      end else if (bank == BANK_FIQ) begin
         slot = FIQ_BASE + int'(idx) - HI_FIRST;
      end else if (int'(idx) < STACK_IDX || bank == BANK_USR) begin
         slot = USR_BASE + int'(idx) - HI_FIRST;
      end else begin
         slot = PRIV_BASE + 2 * (int'(bank) - int'(BANK_IRQ)) + (int'(idx) - STACK_IDX);
      end
      phys = PHYS_W'(slot);
   end

   always_comb begin
      if (bank == BANK_FIQ && int'(idx) >= HI_FIRST && int'(idx) < PC_IDX) begin
         a_r2_fiq_private: assert (int'(phys) >= FIQ_BASE && int'(phys) < PRIV_BASE);
      end
      if (bank != BANK_FIQ && int'(idx) < STACK_IDX) begin
         a_r3_shared_mid: assert (int'(phys) < FIQ_BASE);
      end
   end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
   parameter int DATA_W   = 32,
   parameter int NUM_PHYS = 31,
   parameter int PHYS_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHYS_W-1:0] ra_phys,
   output logic [DATA_W-1:0] ra_data,
   input  logic [PHYS_W-1:0] rb_phys,
   output logic [DATA_W-1:0] rb_data,
   input  logic              wr_en,
   input  logic [PHYS_W-1:0] wr_phys,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lnk_en,
   input  logic [PHYS_W-1:0] lnk_phys,
   input  logic [DATA_W-1:0] lnk_data
);

   if (NUM_PHYS < 2 || (1 << PHYS_W) < NUM_PHYS) begin : g_bad_cfg
      $error("bankreg_store: inconsistent NUM_PHYS / PHYS_W");
   end

   logic [DATA_W-1:0] mem [NUM_PHYS];

   for (genvar i = 0; i < NUM_PHYS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= '0;
         end else if (lnk_en && int'(lnk_phys) == i) begin
            mem[i] <= lnk_data;
         end else if (wr_en && int'(wr_phys) == i) begin
            mem[i] <= wr_data;
         end
      end
   end

   assign ra_data = (int'(ra_phys) < NUM_PHYS) ? mem[ra_phys] : '0;
   assign rb_data = (int'(rb_phys) < NUM_PHYS) ? mem[rb_phys] : '0;

   a_r12_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_en && wr_en && wr_phys == lnk_phys) |=> mem[$past(lnk_phys)] == $past(lnk_data));

endmodule

// File: rtl/bankreg_psr.sv
module bankreg_psr
   import bankreg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMASK_BIT = 7,
   parameter int FMASK_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [MODE_W-1:0] exc_mode,
   input  bank_e             exc_bank,
   input  logic              psr_wr_en,
   input  logic [DATA_W-1:0] psr_wr_data,
   input  logic              restore_en,
   input  logic              saved_wr_en,
   input  logic [DATA_W-1:0] saved_wr_data,
   output bank_e             cur_bank,
   output logic [DATA_W-1:0] psr_q,
   output logic [DATA_W-1:0] saved_rd
);

   if (DATA_W < 8) begin : g_bad_width
      $error("bankreg_psr: DATA_W must hold mode and mask bits");
   end
   if (IMASK_BIT < MODE_W || FMASK_BIT < MODE_W || IMASK_BIT == FMASK_BIT ||
       IMASK_BIT >= DATA_W || FMASK_BIT >= DATA_W) begin : g_bad_bits
      $error("bankreg_psr: mask bit positions invalid");
   end

   localparam logic [DATA_W-1:0] RST_PSR =
      (DATA_W'(1) << IMASK_BIT) | (DATA_W'(1) << FMASK_BIT) | DATA_W'(MODE_SVC);

   logic [DATA_W-1:0] saved_q [NUM_PRIV];
   logic [2:0]        cur_slot;
   logic [2:0]        exc_slot;
   logic              cur_priv;

   assign cur_bank = mode_to_bank(psr_q[MODE_W-1:0]);
   assign cur_priv = (cur_bank != BANK_USR);
   assign cur_slot = cur_priv ? 3'(int'(cur_bank) - 1) : 3'd0;
   assign exc_slot = (exc_bank != BANK_USR) ? 3'(int'(exc_bank) - 1) : 3'd0;
   assign saved_rd = cur_priv ? saved_q[cur_slot] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psr_q <= RST_PSR;
      end else if (exc_valid) begin
         psr_q <= {psr_q[DATA_W-1:MODE_W], exc_mode};
      end else if (restore_en && cur_priv) begin
         psr_q <= saved_q[cur_slot];
      end else if (psr_wr_en) begin
         psr_q <= psr_wr_data;
      end
   end

   for (genvar k = 0; k < NUM_PRIV; k++) begin : g_saved
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            saved_q[k] <= '0;
         end else if (exc_valid && int'(exc_slot) == k) begin
            saved_q[k] <= psr_q;
         end else if (saved_wr_en && cur_priv && int'(cur_slot) == k) begin
            saved_q[k] <= saved_wr_data;
         end
      end
   end

   a_r6_mode_entry: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> psr_q[MODE_W-1:0] == $past(exc_mode));

   a_r6_saved_capture: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> saved_q[$past(exc_slot)] == $past(psr_q));

   a_r7_exc_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_valid && !psr_wr_en && !(restore_en && cur_priv)) |=> $stable(psr_q));

   a_r9_restore_user: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_en && !cur_priv && !exc_valid && !psr_wr_en) |=> $stable(psr_q));

   a_r8_user_saved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_priv |-> saved_rd == '0);

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankreg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMASK_BIT = 7,
   parameter int FMASK_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              exc_take,
   input  logic [4:0]        exc_mode,
   input  logic [DATA_W-1:0] exc_link,
   input  logic              psr_wr_en,
   input  logic [DATA_W-1:0] psr_wr_data,
   input  logic              psr_restore,
   input  logic              saved_wr_en,
   input  logic [DATA_W-1:0] saved_wr_data,
   output logic [DATA_W-1:0] saved_rd_data,
   output logic [DATA_W-1:0] psr_q
);

   localparam int IDX_W  = 4;
   localparam int PHYS_W = $clog2(NUM_PHYS);

   bank_e             cur_bank;
   bank_e             exc_bank;
   logic              exc_valid;
   logic [PHYS_W-1:0] ra_phys, rb_phys, wr_phys, lnk_phys;

   assign exc_bank  = mode_to_bank(exc_mode);
   assign exc_valid = exc_take && (exc_bank != BANK_USR);

   bankreg_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map_a (
      .bank(cur_bank), .idx(rd_a_idx), .phys(ra_phys));

   bankreg_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map_b (
      .bank(cur_bank), .idx(rd_b_idx), .phys(rb_phys));

   bankreg_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map_w (
      .bank(cur_bank), .idx(wr_idx), .phys(wr_phys));

   bankreg_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map_l (
      .bank(exc_bank), .idx(IDX_W'(LINK_IDX)), .phys(lnk_phys));

   bankreg_store #(.DATA_W(DATA_W), .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ra_phys  (ra_phys),
      .ra_data  (rd_a_data),
      .rb_phys  (rb_phys),
      .rb_data  (rd_b_data),
      .wr_en    (wr_en),
      .wr_phys  (wr_phys),
      .wr_data  (wr_data),
      .lnk_en   (exc_valid),
      .lnk_phys (lnk_phys),
      .lnk_data (exc_link)
   );

   bankreg_psr #(.DATA_W(DATA_W), .IMASK_BIT(IMASK_BIT), .FMASK_BIT(FMASK_BIT)) u_psr (
      .clk           (clk),
      .rst_n         (rst_n),
      .exc_valid     (exc_valid),
      .exc_mode      (exc_mode),
      .exc_bank      (exc_bank),
      .psr_wr_en     (psr_wr_en),
      .psr_wr_data   (psr_wr_data),
      .restore_en    (psr_restore),
      .saved_wr_en   (saved_wr_en),
      .saved_wr_data (saved_wr_data),
      .cur_bank      (cur_bank),
      .psr_q         (psr_q),
      .saved_rd      (saved_rd_data)
   );

   a_r7_rejected_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take && !exc_valid && !psr_wr_en && !psr_restore) |=> $stable(psr_q));

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, saved_rd_data, psr_q;
   logic        wr_en = 1'b0, exc_take = 1'b0, psr_wr_en = 1'b0;
   logic        psr_restore = 1'b0, saved_wr_en = 1'b0;
   logic [31:0] wr_data = '0, exc_link = '0, psr_wr_data = '0, saved_wr_data = '0;
   logic [4:0]  exc_mode = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   banked_regfile u_banked_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .exc_take(exc_take), .exc_mode(exc_mode), .exc_link(exc_link),
      .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_restore(psr_restore),
      .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
      .saved_rd_data(saved_rd_data), .psr_q(psr_q));

   // independent model, organised per mode
   logic [31:0] m_low [8];
   logic [31:0] m_usr_hi [7];
   logic [31:0] m_fiq_hi [7];
   logic [31:0] m_sp [4];
   logic [31:0] m_lr [4];
   logic [31:0] m_pc;
   logic [31:0] m_psr;
   logic [31:0] m_saved [5];

   localparam logic [4:0] CODES [7] = '{5'b10000, 5'b10001, 5'b10010,
                                         5'b10011, 5'b10111, 5'b11011, 5'b11111};

   function automatic int bk(input logic [4:0] m);
      case (m)
         5'b10001: return 1;
         5'b10010: return 2;
         5'b10011: return 3;
         5'b10111: return 4;
         5'b11011: return 5;
         default:  return 0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input int b, input int idx);
      if (idx == 15) return m_pc;
      if (idx < 8) return m_low[idx];
      if (b == 1) return m_fiq_hi[idx-8];
      if (b == 0 || idx < 13) return m_usr_hi[idx-8];
      if (idx == 13) return m_sp[b-2];
      return m_lr[b-2];
   endfunction

   task automatic m_write(input int b, input int idx, input logic [31:0] v);
      if (idx == 15) m_pc = v;
      else if (idx < 8) m_low[idx] = v;
      else if (b == 1) m_fiq_hi[idx-8] = v;
      else if (b == 0 || idx < 13) m_usr_hi[idx-8] = v;
      else if (idx == 13) m_sp[b-2] = v;
      else m_lr[b-2] = v;
   endtask

   function automatic string req_tag(input logic [4:0] m, input int idx);
      if (bk(m) == 0 && m != 5'b10000 && idx >= 8 && idx < 15) return "R11";
      if (idx < 8) return "R1";
      if (idx == 15) return "R4";
      if (bk(m) == 1) return "R2";
      return "R3";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      for (int i = 0; i < 8; i++) m_low[i] = '0;
      for (int i = 0; i < 7; i++) begin m_usr_hi[i] = '0; m_fiq_hi[i] = '0; end
      for (int i = 0; i < 4; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
      for (int i = 0; i < 5; i++) m_saved[i] = '0;
      m_pc  = '0;
      m_psr = 32'h0000_00D3;
   endtask

   // inputs are set after a negedge; compare, take the edge, update model
   task automatic cyc();
      int b, tb;
      logic ev;
      logic [31:0] old_psr, npsr;
      #1;
      b = bk(m_psr[4:0]);
      chk(req_tag(m_psr[4:0], int'(rd_a_idx)), rd_a_data, m_read(b, int'(rd_a_idx)));
      chk(req_tag(m_psr[4:0], int'(rd_b_idx)), rd_b_data, m_read(b, int'(rd_b_idx)));
      chk((b == 0) ? "R8" : "R6", saved_rd_data, (b == 0) ? 32'h0 : m_saved[b-1]);
      chk("R6", psr_q, m_psr);
      @(posedge clk);
      tb = bk(exc_mode);
      ev = exc_take && (tb != 0);
      old_psr = m_psr;
      if (wr_en) m_write(b, int'(wr_idx), wr_data);
      if (ev) m_write(tb, 14, exc_link);
      if (ev) npsr = {old_psr[31:5], exc_mode};
      else if (psr_restore && b != 0) npsr = m_saved[b-1];
      else if (psr_wr_en) npsr = psr_wr_data;
      else npsr = old_psr;
      if (saved_wr_en && b != 0) m_saved[b-1] = saved_wr_data;
      if (ev) m_saved[tb-1] = old_psr;
      m_psr = npsr;
      @(negedge clk);
      wr_en = 1'b0; exc_take = 1'b0; psr_wr_en = 1'b0;
      psr_restore = 1'b0; saved_wr_en = 1'b0;
   endtask

   task automatic set_mode(input logic [4:0] m);
      psr_wr_en = 1'b1;
      psr_wr_data = {m_psr[31:5], m};
      cyc();
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] v);
      wr_en = 1'b1; wr_idx = i; wr_data = v;
      cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] seed_val;
      seed_val = $urandom(32'h5EED_1234);
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state, all indices in supervisor mode read zero
      chk("R10", psr_q, 32'h0000_00D3);
      chk("R10", saved_rd_data, 32'h0);
      for (int i = 0; i < 16; i++) begin
         rd_a_idx = 4'(i);
         #1;
         chk("R10", rd_a_data, 32'h0);
      end

      // R5: same-cycle read returns old value, new value next cycle
      rd_a_idx = 4'd5;
      wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'hA5A5_0005;
      #1;
      chk("R5", rd_a_data, 32'h0);
      cyc();
      #1;
      chk("R5", rd_a_data, 32'hA5A5_0005);

      // R2/R3/R1/R4: populate several banks, then read across modes
      set_mode(5'b10000);
      for (int i = 0; i < 16; i++) wr(4'(i), 32'h1000_0000 + i);
      set_mode(5'b10001);
      for (int i = 8; i < 15; i++) wr(4'(i), 32'h2000_0000 + i);
      set_mode(5'b10011);
      wr(4'd13, 32'h3000_000D);
      wr(4'd14, 32'h3000_000E);
      wr(4'd15, 32'h3000_000F);
      foreach (CODES[k]) begin
         set_mode(CODES[k]);
         for (int i = 0; i < 16; i += 2) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i + 1);
            cyc();
         end
      end
      set_mode(5'b10000);
      rd_a_idx = 4'd8; #1;
      chk("R2", rd_a_data, 32'h1000_0008);
      rd_a_idx = 4'd15; #1;
      chk("R4", rd_a_data, 32'h3000_000F);
      set_mode(5'b11111);
      rd_a_idx = 4'd13; #1;
      chk("R11", rd_a_data, 32'h1000_000D);

      // R6: exception from user into interrupt mode
      set_mode(5'b10000);
      exc_take = 1'b1; exc_mode = 5'b10010; exc_link = 32'hCAFE_0014;
      cyc();
      #1;
      chk("R6", psr_q[4:0], 32'(5'b10010));
      rd_a_idx = 4'd14; #1;
      chk("R6", rd_a_data, 32'hCAFE_0014);

      // R7: rejected exception targets
      exc_take = 1'b1; exc_mode = 5'b10000; exc_link = 32'hDEAD_0001;
      cyc();
      exc_take = 1'b1; exc_mode = 5'b11111; exc_link = 32'hDEAD_0002;
      cyc();
      #1;
      chk("R7", psr_q[4:0], 32'(5'b10010));

      // R12: link write beats general write to same slot; exception beats psr write
      wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1111_1111;
      exc_take = 1'b1; exc_mode = 5'b10010; exc_link = 32'h2222_2222;
      psr_wr_en = 1'b1; psr_wr_data = 32'h0000_0010;
      cyc();
      rd_a_idx = 4'd14; #1;
      chk("R12", rd_a_data, 32'h2222_2222);
      chk("R12", psr_q[4:0], 32'(5'b10010));

      // R9: restore in interrupt mode; R8: saved write in privileged vs user
      psr_restore = 1'b1; psr_wr_en = 1'b1; psr_wr_data = 32'h0000_0013;
      cyc();
      chk("R9", psr_q, m_psr);
      set_mode(5'b10000);
      saved_wr_en = 1'b1; saved_wr_data = 32'hBAD0_BAD0;
      psr_restore = 1'b1;
      cyc();
      #1;
      chk("R8", saved_rd_data, 32'h0);
      chk("R9", psr_q[4:0], 32'(5'b10000));
      set_mode(5'b10111);
      saved_wr_en = 1'b1; saved_wr_data = 32'h0000_0097;
      cyc();
      #1;
      chk("R8", saved_rd_data, 32'h0000_0097);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int op;
         op = int'($urandom_range(0, 99));
         rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
         wr_en = ($urandom_range(0, 2) != 0);
         wr_idx = 4'($urandom); wr_data = $urandom;
         if (op < 8) begin
            psr_wr_en = 1'b1;
            psr_wr_data = {$urandom, 5'b0} | 32'(CODES[$urandom_range(0, 6)]);
         end else if (op < 14) begin
            exc_take = 1'b1; exc_mode = CODES[$urandom_range(0, 6)];
            exc_link = $urandom;
            psr_wr_en = ($urandom_range(0, 3) == 0); psr_wr_data = 32'h0000_0010;
            saved_wr_en = ($urandom_range(0, 3) == 0); saved_wr_data = $urandom;
         end else if (op < 18) begin
            psr_restore = 1'b1;
            psr_wr_en = ($urandom_range(0, 1) == 0); psr_wr_data = 32'h0000_0011;
         end else if (op < 24) begin
            saved_wr_en = 1'b1; saved_wr_data = $urandom;
         end
         cyc();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule